// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Responder

This block is an I2C slave that stands in for a small serial EEPROM. Its storage is an internal register array of 1 KB, split into four blocks of 256 bytes. The system clock oversamples the two bus lines. The block finds START and STOP conditions on the bus. It answers device addresses whose top five bits are `10101`, and bits 2:1 of that address pick the block. The first byte written after a write address sets the word address inside the selected block.

Data bytes in a write go into a 16-byte page buffer. They reach the array only when STOP arrives. After that commit the slave stays busy for a set number of clocks, and during that time it answers no address. A master can therefore detect the end of programming by acknowledge polling.

Reads can be current-address or random. A random read is a dummy write followed by a repeated START. A read continues byte after byte until the master answers with a NACK. The block only pulls SDA low. It uses an open-drain enable and changes it only while SCL is low.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, sdaOe is 0 and every array byte reads back as 0xFF.
- R2: The slave pulls SDA low in the ninth clock of a device-address byte only when bits 7:3 are 10101 (0xA8, 0xAA, 0xAC, 0xAE with R/W in bit 0). Any other address gets no acknowledge, and the slave stays released for the following bytes until the next START.
- R3: Device-address bits 2:1 select one of four 256-byte blocks. Blocks do not alias each other.
- R4: The first byte after a matching write address is acknowledged and loaded as the 8-bit word address.
- R5: Every data byte of a write is acknowledged. The bytes are committed only at STOP. A repeated START discards them and starts no programming period.
- R6: Successive data bytes use word-address bits 3:0 modulo 16, so they stay inside the aligned 16-byte page. A 17th byte overwrites the first.
- R7: A repeated START with R/W=1 after a dummy write returns data starting at the word address that was loaded.
- R8: A sequential read increments the low 8 pointer bits and wraps from 0xFF to 0x00 within the same block. After a master NACK the slave releases SDA and sends nothing more.
- R9: A read that starts directly with R/W=1 continues from the pointer left by the previous access.
- R10: After the STOP of a write that carried at least one data byte, the slave acknowledges no address for PROG_CYCLES clocks. After that it acknowledges again.
- R11: sdaOe changes only while SCL is low. It is high only during an acknowledge or while a 0 read bit is being sent.
- R12: A write transaction that carries only a word address starts no programming period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Sensed level of the serial clock line |
| sdaIn | input | 1 | Sensed level of the serial data line |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest state to reach from the pins is a page buffer that has wrapped: 17 bytes must be written from one page start, and the wrapped slot must then be read back across a block boundary. The stimulus writes 17 bytes into block 2. It then starts a random read at 0xFF in that block, so a single two-byte read shows both the block wrap and the overwritten first slot. The busy window is checked with an acknowledge poll sent right after STOP, and with a second poll sent once the window has passed.

// File: rtl/ee_pkg.sv
package ee_pkg;
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} eeState_e;
  typedef enum logic [1:0] {K_DEV, K_WORD, K_DATA} eeKind_e;

  // one-cycle commands from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic setDev;
    logic loadWord;
    logic storeData;
    logic loadTx;
    logic shiftTx;
    logic incRead;
    logic commit;
    logic clearBuf;
  } eeStrobe_t;
endpackage

// File: rtl/ee_bus_sense.sv
module ee_bus_sense (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [1:0] sclSync, sdaSync;
  logic sclP, sdaP, sclS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclP    <= sclSync[1];
      sdaP    <= sdaSync[1];
    end
  end

  assign sclS    = sclSync[1];
  assign sdaS    = sdaSync[1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
  import ee_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       addrHit,
  input  logic       rwBit,
  input  logic       txBit,
  input  logic       busy,
  output eeStrobe_t  str,
  output logic       sdaOe
);
  eeState_e   state, stateD;
  eeKind_e    kind, kindD;
  logic [3:0] bitCnt, cntD;
  logic       rw, rwD, wrMode, wrD, mAck, mAckD;

  always_comb begin
    str    = '0;
    stateD = state;
    kindD  = kind;
    cntD   = bitCnt;
    rwD    = rw;
    wrD    = wrMode;
    mAckD  = mAck;
    if (startEv) begin
      str.clearBuf = 1'b1;
      stateD = S_RX;
      kindD  = K_DEV;
      cntD   = '0;
    end else if (stopEv) begin
      str.commit = wrMode;
      wrD    = 1'b0;
      stateD = S_IDLE;
    end else begin
      case (state)
        S_RX: begin
          if (sclRise) begin
            str.shiftIn = 1'b1;
            cntD = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            cntD = '0;
            case (kind)
              K_DEV: begin
                if (addrHit && !busy) begin
                  str.setDev = 1'b1;
                  rwD    = rwBit;
                  wrD    = !rwBit;
                  kindD  = K_WORD;
                  stateD = S_ACK;
                end else begin
                  wrD    = 1'b0;
                  stateD = S_IDLE;
                end
              end
              K_WORD: begin
                str.loadWord = 1'b1;
                kindD  = K_DATA;
                stateD = S_ACK;
              end
              default: begin
                str.storeData = 1'b1;
                stateD = S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (sclFall) begin
            cntD = '0;
            if (rw) begin
              str.loadTx = 1'b1;
              stateD = S_TX;
            end else begin
              stateD = S_RX;
            end
          end
        end
        S_TX: begin
          if (sclRise) begin
            cntD = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              str.incRead = 1'b1;
              stateD = S_MACK;
            end else begin
              str.shiftTx = 1'b1;
            end
          end
        end
        S_MACK: begin
          if (sclRise) begin
            mAckD = !sdaS;
          end else if (sclFall) begin
            cntD = '0;
            if (mAck) begin
              str.loadTx = 1'b1;
              stateD = S_TX;
            end else begin
              stateD = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      kind   <= K_DEV;
      bitCnt <= '0;
      rw     <= 1'b0;
      wrMode <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateD;
      kind   <= kindD;
      bitCnt <= cntD;
      rw     <= rwD;
      wrMode <= wrD;
      mAck   <= mAckD;
    end
  end

  assign sdaOe = (state == S_ACK) || (state == S_TX && !txBit);
endmodule

// File: rtl/ee_data.sv
module ee_data
  import ee_pkg::*;
#(
  parameter int         BLOCKS      = 4,
  parameter int         BLOCK_BYTES = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         PROG_CYCLES = 2000,
  parameter logic [4:0] DEV_PREFIX  = 5'b10101
) (
  input  logic      clk,
  input  logic      rstN,
  input  eeStrobe_t str,
  input  logic      sdaS,
  output logic      addrHit,
  output logic      rwBit,
  output logic      txBit,
  output logic      busy
);
  localparam int BLK_W     = $clog2(BLOCKS);
  localparam int WORD_W    = $clog2(BLOCK_BYTES);
  localparam int PAGE_W    = $clog2(PAGE_BYTES);
  localparam int ADDR_W    = BLK_W + WORD_W;
  localparam int MEM_BYTES = BLOCKS * BLOCK_BYTES;
  localparam int BUSY_W    = $clog2(PROG_CYCLES + 1);

  logic [7:0]            mem [MEM_BYTES];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [ADDR_W-1:0]     ptr;
  logic [7:0]            rxShift, txShift;
  logic [BUSY_W-1:0]     busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= 8'hFF;
    end else begin
      if (str.shiftIn) rxShift <= {rxShift[6:0], sdaS};
      if (str.loadTx)       txShift <= mem[ptr];
      else if (str.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      pageValid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else begin
      if (str.setDev)   ptr[ADDR_W-1:WORD_W] <= rxShift[BLK_W:1];
      if (str.loadWord) ptr[WORD_W-1:0] <= rxShift[WORD_W-1:0];
      if (str.incRead)  ptr[WORD_W-1:0] <= ptr[WORD_W-1:0] + 1'b1;
      if (str.storeData) begin
        pageBuf[ptr[PAGE_W-1:0]]   <= rxShift;
        pageValid[ptr[PAGE_W-1:0]] <= 1'b1;
        ptr[PAGE_W-1:0]            <= ptr[PAGE_W-1:0] + 1'b1;
      end
      if (str.clearBuf || str.commit) pageValid <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (str.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pageValid[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         busyCnt <= '0;
    else if (str.commit && |pageValid) busyCnt <= BUSY_W'(PROG_CYCLES);
    else if (busyCnt != '0)            busyCnt <= busyCnt - 1'b1;
  end

  assign busy    = (busyCnt != '0);
  assign addrHit = (rxShift[7:3] == DEV_PREFIX);
  assign rwBit   = rxShift[0];
  assign txBit   = txShift[7];
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import ee_pkg::*;
#(
  parameter int         BLOCKS      = 4,
  parameter int         BLOCK_BYTES = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         PROG_CYCLES = 2000,
  parameter logic [4:0] DEV_PREFIX  = 5'b10101
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);
  eeStrobe_t str;
  logic sdaS, sclRise, sclFall, startEv, stopEv;
  logic addrHit, rwBit, txBit, busy;

  ee_bus_sense u_sense (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  ee_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .addrHit(addrHit), .rwBit(rwBit),
    .txBit(txBit), .busy(busy), .str(str), .sdaOe(sdaOe)
  );

  ee_data #(
    .BLOCKS(BLOCKS), .BLOCK_BYTES(BLOCK_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .PROG_CYCLES(PROG_CYCLES), .DEV_PREFIX(DEV_PREFIX)
  ) u_data (
    .clk(clk), .rstN(rstN), .str(str), .sdaS(sdaS),
    .addrHit(addrHit), .rwBit(rwBit), .txBit(txBit), .busy(busy)
  );
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk
  import ee_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclIn,
  input logic      sdaIn,
  input logic      sdaOe,
  input logic      busy,
  input eeStrobe_t str
);
  // R11: the open-drain enable moves only while the clock line is low
  a_r11_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclIn);

  // R10: nothing is driven during the programming window
  a_r10_busy_silent: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  // R10: a programming window opens only on an idle bus after STOP
  a_r10_busy_on_idle_bus: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (sclIn && sdaIn));

  // R5: programming begins only from a commit at STOP
  a_r5_busy_from_commit: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(str.commit));

  // R11: control issues at most one datapath action per cycle
  a_r11_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(str));
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
  .sdaOe(sdaOe), .busy(busy), .str(str)
);

// File: tb/tb_eeprom_i2c_slave.sv
module tb_eeprom_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam int PROG       = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic sdaLine;
  assign sdaLine = mSda & ~sdaOe;

  eeprom_i2c_slave dut (.clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaOe(sdaOe));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nRun = 0, nFail = 0, edgeBad = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [7:0] gotQ [$];
  logic [7:0] wq   [$];
  logic [7:0] model [1024];
  logic       oePrev = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // R11 monitor: enable must not move while SCL is high
  always @(posedge clk) begin
    if (rstN && sdaOe !== oePrev && mScl) edgeBad++;
    oePrev <= sdaOe;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (gotQ.size() > 0) begin
      logic [7:0] g;
      g = gotQ.pop_front();
      if (expQ.size() == 0) check(1'b0, "unexpected read byte", g, 0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  task automatic quarter();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bitX(input bit b, output bit s);
    quarter(); mSda = b;
    quarter(); mScl = 1'b1;
    quarter(); s = sdaLine;
    quarter(); mScl = 1'b0;
  endtask

  task automatic busStart();
    quarter(); mSda = 1'b1;
    quarter(); mScl = 1'b1;
    quarter(); mSda = 1'b0;
    quarter(); mScl = 1'b0;
  endtask

  task automatic busStop();
    quarter(); mSda = 1'b0;
    quarter(); mScl = 1'b1;
    quarter(); mSda = 1'b1;
    quarter(); quarter();
  endtask

  task automatic writeByte(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) bitX(d[i], s);
    bitX(1'b1, s);
    ack = !s;
  endtask

  task automatic readByte(input bit more);
    bit s;
    logic [7:0] d;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bitX(1'b1, s);
      d = {d[6:0], s};
    end
    bitX(!more, s);
    gotQ.push_back(d);
  endtask

  task automatic expectByte(input logic [7:0] v, input string tag);
    expQ.push_back(v);
    tagQ.push_back(tag);
  endtask

  // page write of the bytes in wq; model follows the page-wrap rule (R6)
  task automatic pageWrite(input logic [7:0] dev, input logic [7:0] addr);
    bit ack;
    busStart();
    writeByte(dev, ack);  check(ack, "R2 device address ack", ack, 1);
    writeByte(addr, ack); check(ack, "R4 word address ack", ack, 1);
    for (int i = 0; i < wq.size(); i++) begin
      logic [3:0] low;
      writeByte(wq[i], ack); check(ack, "R5 data byte ack", ack, 1);
      low = addr[3:0] + 4'(i);
      model[{dev[2:1], addr[7:4], low}] = wq[i];
    end
    busStop();
  endtask

  task automatic randRead(input logic [7:0] dev, input logic [7:0] addr, input int n, input string tag);
    bit ack;
    busStart();
    writeByte({dev[7:1], 1'b0}, ack); check(ack, "R7 dummy write ack", ack, 1);
    writeByte(addr, ack);             check(ack, "R4 word address ack", ack, 1);
    busStart();
    writeByte({dev[7:1], 1'b1}, ack); check(ack, "R7 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] a;
      a = addr + 8'(i);
      expectByte(model[{dev[2:1], a}], tag);
      readByte(i < n - 1);
    end
    busStop();
  endtask

  task automatic waitBusy();
    repeat (PROG + 200) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    bit ack;
    for (int i = 0; i < 1024; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    check(sdaOe == 1'b0, "R1 reset release", sdaOe, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R5: write two bytes into block 3
    wq = {8'h05, 8'hE0};
    pageWrite(8'hAE, 8'h00);
    // R10: poll during programming must see no ack
    busStart(); writeByte(8'hAE, ack); busStop();
    check(!ack, "R10 nack while busy", ack, 0);
    waitBusy();
    // R10: ack returns; R12: address-only write leaves no busy
    busStart(); writeByte(8'hAE, ack); writeByte(8'h00, ack); busStop();
    check(ack, "R10 ack after busy", ack, 1);
    busStart(); writeByte(8'hAE, ack); busStop();
    check(ack, "R12 no busy without data", ack, 1);

    // R7/R8: random sequential read
    randRead(8'hAE, 8'h00, 2, "R7 random read");
    // R9: current-address read continues from pointer 0x01
    randRead(8'hAE, 8'h00, 1, "R7 single read");
    busStart(); writeByte(8'hAF, ack); check(ack, "R9 current read ack", ack, 1);
    expectByte(model[{2'd3, 8'h01}], "R9 current address read");
    readByte(1'b0); busStop();
    check(sdaOe == 1'b0, "R8 released after nack", sdaOe, 0);

    // R3/R1: block 0 untouched, still erased
    randRead(8'hA8, 8'h00, 1, "R3 block isolation");

    // R6: page wrap in block 1
    wq = {8'h11, 8'h22, 8'h33, 8'h44};
    pageWrite(8'hAA, 8'h1E);
    waitBusy();
    randRead(8'hAA, 8'h10, 2, "R6 wrapped bytes");
    randRead(8'hAA, 8'h1E, 3, "R6 page boundary");

    // R6: 17 bytes, last overwrites the first slot
    wq = {};
    for (int i = 0; i < 17; i++) wq.push_back(8'h80 + 8'(i));
    pageWrite(8'hAC, 8'h00);
    waitBusy();
    check(model[{2'd2, 8'h00}] == 8'h90, "R6 model slot0", model[{2'd2, 8'h00}], 8'h90);
    randRead(8'hAC, 8'h01, 2, "R6 page contents");
    // R8: block wrap 0xFF -> 0x00 within block 2
    randRead(8'hAC, 8'hFF, 2, "R8 block wrap");

    // R5: repeated START discards buffered data
    busStart();
    writeByte(8'hA8, ack); writeByte(8'h05, ack); writeByte(8'h77, ack);
    check(ack, "R5 data ack before abort", ack, 1);
    busStart(); writeByte(8'hA9, ack);
    check(ack, "R5 read after abort ack", ack, 1);
    expectByte(8'hFF, "R5 aborted byte not stored");
    readByte(1'b0); busStop();
    busStart(); writeByte(8'hA8, ack); busStop();
    check(ack, "R5 abort starts no busy", ack, 1);
    randRead(8'hA8, 8'h05, 1, "R5 array unchanged");

    // R2: foreign address ignored until next START
    busStart();
    writeByte(8'hA0, ack); check(!ack, "R2 foreign address nack", ack, 0);
    writeByte(8'h00, ack); check(!ack, "R2 silent after mismatch", ack, 0);
    busStop();

    repeat (20) @(negedge clk);
    check(edgeBad == 0, "R11 enable moved with SCL high", edgeBad, 0);
    check(sdaOe == 1'b0, "R11 idle release", sdaOe, 0);
    check(expQ.size() == 0, "scoreboard drained", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule